// File: doc/BRIEF.md
# Carrier-Detect Receive Gating Controller

This block sits between a serial receive pin pair and a downstream deframer. It qualifies each received bit with a carrier-detect input. A bit reaches the deframer only while carrier is present, or, in pulse mode, while a reception that a carrier assertion started is still running. One bit is presented on every rising edge of the receive clock. For character-oriented (asynchronous) links the same gating applies, so the first bit let through is the start bit of the first character.

Two static configuration bits choose the behaviour. The direct-sampling bit chooses how carrier is seen. In synchronous sampling the pin passes through a synchronizer on the receive clock first. In direct sampling the pin gates reception combinationally with no delay. Direct sampling relies on every carrier transition arriving while the receive clock is low. The pulse-mode bit chooses what a carrier drop means. In envelope mode a drop ends reception, and a drop inside a frame marks that frame as carrier-lost. In pulse mode a drop changes nothing: reception runs on until the deframer reports frame end, and carrier-lost is never raised.

The deframer marks frame boundaries with single-cycle start and end strobes. One cycle after each end strobe the block issues a frame-done strobe together with the carrier-lost status of that frame.

Top module: `cdgate_top`

## Requirements
- R1: While and after reset with no carrier, bit_valid is 0, rx_halt is 1, bit_data is 0, frame_done is 0 and carrier_lost is 0.
- R2: The carrier pin is active-low: cd_n = 0 means carrier present, cd_n = 1 means carrier absent.
- R3: With cfg_direct = 0, a change on cd_n reaches bit_valid and rx_halt only after the second rising edge of rx_clk that follows the change, and not after the first.
- R4: With cfg_direct = 1, a change on cd_n reaches bit_valid and rx_halt in the same cycle, before any clock edge.
- R5: In envelope mode (cfg_pulse = 0), carrier absent forces bit_valid = 0, rx_halt = 1 and bit_data = 0.
- R6: In envelope mode, if carrier is absent on any rising edge from the frame_start edge to the frame_end edge, carrier_lost = 1 is reported with frame_done.
- R7: In envelope mode, a frame with carrier present on every edge from frame_start to frame_end reports carrier_lost = 0.
- R8: In pulse mode (cfg_pulse = 1), after carrier has been present on one rising edge, bit_valid stays 1 through a carrier drop up to and including the frame_end cycle. The block halts after that edge if carrier is absent, and carrier_lost is reported as 0.
- R9: frame_start clears the carrier-lost history, so a clean frame that follows a lost frame reports carrier_lost = 0.
- R10: frame_done is 1 for exactly the one cycle after each rising edge on which frame_end is 1. carrier_lost is updated on that edge and holds until the next frame end.
- R11: While bit_valid is 1, bit_data equals rx_data, for both values of rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 1 | Serial receive data |
| cd_n | input | 1 | Carrier-detect pin, active low |
| frame_start | input | 1 | Deframer strobe at the first bit of a frame |
| frame_end | input | 1 | Deframer strobe at the last bit of a frame |
| cfg_direct | input | 1 | 1 = immediate carrier gating, 0 = synchronized |
| cfg_pulse | input | 1 | 1 = pulse mode, 0 = envelope mode |
| bit_valid | output | 1 | Gated bit strobe |
| bit_data | output | 1 | Gated data bit, 0 when not valid |
| rx_halt | output | 1 | Reception halted |
| frame_done | output | 1 | One-cycle strobe after frame end |
| carrier_lost | output | 1 | Carrier-lost status of the last finished frame |

## Verification
The carrier pin is toggled in both sampling modes. The bench checks gating in the same cycle and then after one and after two receive clock edges, which separates the direct path from the synchronized one and counts the synchronizer depth exactly. Frames are run with a one-cycle carrier drop in the middle, with carrier held throughout, and as a clean frame right after a lost one. These show whether loss is accumulated over the frame and whether frame start clears it. A pulse-mode frame with the carrier dropping mid-frame shows whether reception persists up to frame end and whether the lost flag stays clear. Data bits of both values confirm that the gated bit follows the pin only while valid.

// File: rtl/cdgate_pkg.sv
package cdgate_pkg;
   typedef struct packed {
      logic direct;
      logic pulse;
   } cdgate_cfg_t;

   localparam int unsigned CDGATE_MIN_STAGES = 2;
endpackage

// File: rtl/cdgate_sync.sv
module cdgate_sync
   import cdgate_pkg::*;
#(
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic carrier_raw,
   output logic carrier_sync
);
   localparam int unsigned LAST = STAGES - 1;

   initial begin
      if (STAGES < CDGATE_MIN_STAGES)
         $error("cdgate_sync: STAGES must be at least %0d", CDGATE_MIN_STAGES);
   end

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign carrier_raw = ~pin;
      end else begin : g_pass
         assign carrier_raw = pin;
      end
   endgenerate

   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[LAST-1:0], carrier_raw};
   end

   assign carrier_sync = chain_q[LAST];
endmodule

// File: rtl/cdgate_gate.sv
module cdgate_gate
   import cdgate_pkg::*;
#(
   parameter int unsigned DATA_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cdgate_cfg_t       cfg,
   input  logic              carrier_raw,
   input  logic              carrier_sync,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              frame_end,
   output logic              carrier,
   output logic              bit_valid,
   output logic [DATA_W-1:0] bit_data,
   output logic              rx_halt
);
   logic running_q;
   logic gate;

   initial begin
      if (DATA_W < 1) $error("cdgate_gate: DATA_W must be positive");
   end

   always_comb begin
      carrier = cfg.direct ? carrier_raw : carrier_sync;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         running_q <= 1'b0;
      else if (frame_end) running_q <= 1'b0;
      else                running_q <= cfg.pulse & (running_q | carrier);
   end

   always_comb begin
      gate      = carrier | (cfg.pulse & running_q);
      bit_valid = gate;
      rx_halt   = ~gate;
      bit_data  = gate ? rx_data : '0;
   end
endmodule

// File: rtl/cdgate_status.sv
module cdgate_status
   import cdgate_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  cdgate_cfg_t cfg,
   input  logic        carrier,
   input  logic        frame_start,
   input  logic        frame_end,
   output logic        frame_done,
   output logic        carrier_lost
);
   logic in_frame_q;
   logic lost_acc_q;
   logic lost_hit;

   assign lost_hit = (in_frame_q | frame_start) & ~carrier & ~cfg.pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q   <= 1'b0;
         lost_acc_q   <= 1'b0;
         frame_done   <= 1'b0;
         carrier_lost <= 1'b0;
      end else begin
         frame_done <= frame_end;
         if (frame_end) begin
            in_frame_q   <= 1'b0;
            lost_acc_q   <= 1'b0;
            carrier_lost <= (lost_acc_q | lost_hit) & ~cfg.pulse;
         end else if (frame_start) begin
            in_frame_q <= 1'b1;
            lost_acc_q <= lost_hit;
         end else begin
            lost_acc_q <= lost_acc_q | lost_hit;
         end
      end
   end
endmodule

// File: rtl/cdgate_top.sv
module cdgate_top
   import cdgate_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CD_ACT_LOW  = 1'b1
) (
   input  logic rx_clk,
   input  logic rst_n,
   input  logic rx_data,
   input  logic cd_n,
   input  logic frame_start,
   input  logic frame_end,
   input  logic cfg_direct,
   input  logic cfg_pulse,
   output logic bit_valid,
   output logic bit_data,
   output logic rx_halt,
   output logic frame_done,
   output logic carrier_lost
);
   cdgate_cfg_t cfg;
   logic        carrier_raw;
   logic        carrier_sync;
   logic        carrier;

   assign cfg.direct = cfg_direct;
   assign cfg.pulse  = cfg_pulse;

   cdgate_sync #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(CD_ACT_LOW)) u_sync (
      .clk(rx_clk), .rst_n(rst_n), .pin(cd_n),
      .carrier_raw(carrier_raw), .carrier_sync(carrier_sync)
   );

   cdgate_gate #(.DATA_W(1)) u_gate (
      .clk(rx_clk), .rst_n(rst_n), .cfg(cfg),
      .carrier_raw(carrier_raw), .carrier_sync(carrier_sync),
      .rx_data(rx_data), .frame_end(frame_end),
      .carrier(carrier), .bit_valid(bit_valid),
      .bit_data(bit_data), .rx_halt(rx_halt)
   );

   cdgate_status u_status (
      .clk(rx_clk), .rst_n(rst_n), .cfg(cfg), .carrier(carrier),
      .frame_start(frame_start), .frame_end(frame_end),
      .frame_done(frame_done), .carrier_lost(carrier_lost)
   );
endmodule

// File: rtl/cdgate_chk.sv
module cdgate_chk #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic rx_clk,
   input logic rst_n,
   input logic cfg_pulse,
   input logic frame_end,
   input logic bit_valid,
   input logic frame_done,
   input logic carrier_lost,
   input logic carrier,
   input logic carrier_raw,
   input logic carrier_sync
);
   logic [1:0] age_q;

   always_ff @(posedge rx_clk or negedge rst_n) begin
      if (!rst_n)          age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R5: envelope mode never passes a bit without carrier
   p_env_gate_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
      (!cfg_pulse && bit_valid) |-> carrier);

   // R8: pulse mode never reports carrier lost
   p_pulse_nolost_r8: assert property (@(posedge rx_clk) disable iff (!rst_n)
      (cfg_pulse && frame_end) |=> !carrier_lost);

   // R8: pulse-mode reception persists until frame end
   p_pulse_hold_r8: assert property (@(posedge rx_clk) disable iff (!rst_n)
      (cfg_pulse && bit_valid && !frame_end) |=> (!cfg_pulse || bit_valid));

   // R10: frame done follows frame end by one cycle
   p_done_follow_r10: assert property (@(posedge rx_clk) disable iff (!rst_n)
      frame_end |=> frame_done);

   // R10: no frame done without a frame end
   p_done_only_r10: assert property (@(posedge rx_clk) disable iff (!rst_n)
      !frame_end |=> !frame_done);

   generate
      if (SYNC_STAGES == 2) begin : g_lag
         // R3: synchronized carrier lags the pin by two edges
         p_sync_lag_r3: assert property (@(posedge rx_clk) disable iff (!rst_n)
            (age_q >= 2'd2) |-> (carrier_sync == $past(carrier_raw, 2)));
      end
   endgenerate
endmodule

bind cdgate_top cdgate_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .rx_clk(rx_clk), .rst_n(rst_n), .cfg_pulse(cfg_pulse),
   .frame_end(frame_end), .bit_valid(bit_valid), .frame_done(frame_done),
   .carrier_lost(carrier_lost), .carrier(carrier),
   .carrier_raw(carrier_raw), .carrier_sync(carrier_sync)
);

// File: tb/sim_cdgate_top.sv
`timescale 1ns/1ps
module sim_cdgate_top;
   logic rx_clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_data = 1'b0;
   logic cd_n = 1'b1;
   logic frame_start = 1'b0;
   logic frame_end = 1'b0;
   logic cfg_direct = 1'b1;
   logic cfg_pulse = 1'b0;
   logic bit_valid, bit_data, rx_halt, frame_done, carrier_lost;

   int checks = 0;
   int errors = 0;

   always #10 rx_clk = ~rx_clk;

   cdgate_top u0 (
      .rx_clk(rx_clk), .rst_n(rst_n), .rx_data(rx_data), .cd_n(cd_n),
      .frame_start(frame_start), .frame_end(frame_end),
      .cfg_direct(cfg_direct), .cfg_pulse(cfg_pulse),
      .bit_valid(bit_valid), .bit_data(bit_data), .rx_halt(rx_halt),
      .frame_done(frame_done), .carrier_lost(carrier_lost)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // advance one rising edge, land on the following falling edge
   task automatic tick();
      @(posedge rx_clk);
      @(negedge rx_clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic t_reset();
      chk("R1 valid in reset", bit_valid, 1'b0);
      chk("R1 halt in reset", rx_halt, 1'b1);
      @(negedge rx_clk); rst_n = 1'b1;
      tick();
      chk("R1 valid", bit_valid, 1'b0);
      chk("R1 halt", rx_halt, 1'b1);
      chk("R1 data", bit_data, 1'b0);
      chk("R1 done", frame_done, 1'b0);
      chk("R1 lost", carrier_lost, 1'b0);
   endtask

   task automatic t_direct();
      cfg_direct = 1'b1; cfg_pulse = 1'b0;
      rx_data = 1'b1; cd_n = 1'b0; settle();
      chk("R2 R4 valid on low pin", bit_valid, 1'b1);
      chk("R4 halt cleared", rx_halt, 1'b0);
      chk("R11 data one", bit_data, 1'b1);
      rx_data = 1'b0; settle();
      chk("R11 data zero", bit_data, 1'b0);
      tick();
      rx_data = 1'b1; cd_n = 1'b1; settle();
      chk("R4 R5 valid drops", bit_valid, 1'b0);
      chk("R5 halt", rx_halt, 1'b1);
      chk("R5 data masked", bit_data, 1'b0);
      tick();
   endtask

   task automatic t_sync();
      cfg_direct = 1'b0; cfg_pulse = 1'b0;
      tick(); tick();
      cd_n = 1'b0; settle();
      chk("R3 no immediate", bit_valid, 1'b0);
      tick();
      chk("R3 not after one edge", bit_valid, 1'b0);
      tick();
      chk("R3 valid after two edges", bit_valid, 1'b1);
      cd_n = 1'b1; tick();
      chk("R3 still valid after one edge", bit_valid, 1'b1);
      tick();
      chk("R3 halt after two edges", rx_halt, 1'b1);
      cfg_direct = 1'b1;
      tick();
   endtask

   task automatic t_env_lost();
      cfg_direct = 1'b1; cfg_pulse = 1'b0;
      cd_n = 1'b0; frame_start = 1'b1; tick();
      frame_start = 1'b0; tick(); tick();
      cd_n = 1'b1; tick();
      cd_n = 1'b0; tick();
      frame_end = 1'b1; tick();
      frame_end = 1'b0;
      chk("R6 lost flagged", carrier_lost, 1'b1);
      chk("R10 done strobe", frame_done, 1'b1);
      tick();
      chk("R10 done one cycle", frame_done, 1'b0);
      chk("R10 lost held", carrier_lost, 1'b1);
   endtask

   task automatic t_env_clean();
      cd_n = 1'b0; frame_start = 1'b1; tick();
      frame_start = 1'b0; tick(); tick(); tick();
      frame_end = 1'b1; tick();
      frame_end = 1'b0;
      chk("R7 R9 clean frame", carrier_lost, 1'b0);
      chk("R10 done strobe clean", frame_done, 1'b1);
      cd_n = 1'b1; tick();
   endtask

   task automatic t_pulse();
      cfg_direct = 1'b1; cfg_pulse = 1'b1;
      cd_n = 1'b0; frame_start = 1'b1; tick();
      frame_start = 1'b0;
      cd_n = 1'b1; settle();
      chk("R8 valid after drop", bit_valid, 1'b1);
      chk("R8 no halt after drop", rx_halt, 1'b0);
      tick(); tick();
      chk("R8 still running", bit_valid, 1'b1);
      frame_end = 1'b1; settle();
      chk("R8 valid on last bit", bit_valid, 1'b1);
      tick();
      frame_end = 1'b0;
      chk("R8 no lost", carrier_lost, 1'b0);
      chk("R10 done pulse mode", frame_done, 1'b1);
      chk("R8 halted after end", rx_halt, 1'b1);
      cfg_pulse = 1'b0;
      tick();
   endtask

   initial begin
      t_reset();
      t_direct();
      t_sync();
      t_env_lost();
      t_env_clean();
      t_pulse();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule